// File: doc/BRIEF.md
# Integer Add/Shift Execute Stage

This block is the purely combinational execute step of a 64-bit integer pipeline in the classic load/store style. Within a single cycle it turns an opcode select, two 64-bit source operands, a 16-bit instruction immediate, a 5-bit constant shift amount and a 5-bit destination index into a 64-bit result, a register-file write enable and an overflow exception indication.

It covers three groups of operations:
- **Arithmetic.** Addition and subtraction, each at word (32-bit) or doubleword (64-bit) width, each in a trapping or a wrapping flavour, with register and immediate forms.
- **Logic and compare.** Bitwise logic with register or zero-extended immediate operands, signed and unsigned set-on-less-than, and load-upper-immediate.
- **Shifts.** Left, logical-right and arithmetic-right shifts at word and doubleword width. The amount comes from the instruction field or from the first source operand.

Every word-width result is sign-extended into the full 64 bits. This holds for logical right shifts too. A trapping overflow is always reported, even when the destination is register zero. Decode, the register file, forwarding and the exception handler sit around this block and are not part of it.

Top module: `exu_int_alu`

## Requirements
- R1: Opcode encoding on `op_i`. 0 add32-trap, 1 add32-wrap, 2 sub32-trap, 3 sub32-wrap, 4 add64-trap, 5 add64-wrap, 6 sub64-trap, 7 sub64-wrap, 8 add32-imm-trap, 9 add32-imm-wrap, 10 add64-imm-trap, 11 add64-imm-wrap, 12 and, 13 or, 14 xor, 15 nor, 16 and-imm, 17 or-imm, 18 xor-imm, 19 load-upper-imm, 20 slt, 21 sltu, 22 slt-imm, 23 sltu-imm, 24 shl32, 25 shr32, 26 sra32, 27 to 29 the same three with a register amount, 30 shl64, 31 shr64, 32 sra64, 33 to 35 the same three shifting by amount plus 32, 36 to 38 the same three with a register amount. Codes 39 to 63 are unused: result 0, no write, no overflow.
- R2: Wrapping word add/sub (codes 1, 3, 9) adds or subtracts the low 32 bits of the operands, sign-extends the 32-bit outcome to 64 bits and never flags overflow. Immediate forms use the sign-extended immediate as the second operand.
- R3: Trapping word add/sub (codes 0, 2, 8) forms the 33-bit signed sum. It flags overflow when sum bit 32 differs from bit 31. When flagged, `exc_code_o` is 0x30; otherwise it is 0.
- R4: Doubleword add/sub (codes 4 to 7, 10, 11) produces the 64-bit wrapped result. The trapping codes (4, 6, 10) flag overflow when the true signed result lies outside the 64-bit range.
- R5: `wr_en_o` is 0 whenever `dest_i` is 0, and the overflow flag is still raised for a trapping op with destination 0.
- R6: An overflow suppresses the write (`wr_en_o` = 0) in the same cycle. Any other valid op with a nonzero destination asserts `wr_en_o`.
- R7: Logic ops compute and, or, xor and nor over 64 bits. The immediate forms zero-extend the 16-bit immediate.
- R8: Compare ops give 1 or 0. Codes 20 and 22 compare signed; codes 21 and 23 compare unsigned. The immediate forms sign-extend the immediate before comparing.
- R9: Load-upper-immediate places the immediate in bits 31:16, clears bits 15:0 and sign-extends from bit 31.
- R10: Word shifts act on the low 32 bits of `src_b_i` and sign-extend the 32-bit outcome, logical right shifts included. The amount is `shamt_i` for the constant forms and `src_a_i[4:0]` for the register forms.
- R11: Doubleword shifts act on all 64 bits of `src_b_i`. The amount is `shamt_i`, `shamt_i`+32, or `src_a_i[5:0]` for the constant, plus-32 and register forms respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Operation select (encoding in R1) |
| src_a_i | input | 64 | First source operand; also the register shift amount |
| src_b_i | input | 64 | Second source operand; the value being shifted |
| imm_i | input | 16 | Raw instruction immediate |
| shamt_i | input | 5 | Constant shift amount field |
| dest_i | input | 5 | Destination register index |
| result_o | output | 64 | Computed result |
| wr_en_o | output | 1 | Register-file write enable |
| ovf_o | output | 1 | Overflow exception flag for trapping arithmetic |
| exc_code_o | output | 6 | Exception code, 0x30 on overflow, else 0 |

## Verification
The embedded checks assume that every input is stable and fully known when they are evaluated, because the stage holds no state and is judged only on settled values. The bench therefore changes all inputs together just after a clock edge and samples half a period later. It takes operands from a small set of sign-boundary and bit-pattern corners: the word and doubleword limits, all ones, and 0x80000000. The destination index is rotated through zero so that the write-enable and overflow properties meet both of their branches. It also chooses shift amounts at 0, 1, 31 and beyond 31, so that the 32-bit variable-amount masking and the plus-32 forms are exercised at their edges.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int XLEN  = 64;
  localparam int HLEN  = XLEN / 2;
  localparam int SHW   = $clog2(XLEN);
  localparam int IMMW  = 16;
  localparam int OPW   = 6;
  localparam int REGW  = 5;
  localparam int EXCW  = 6;
  localparam logic [EXCW-1:0] EXC_OVF = 6'h30;

  typedef enum logic [OPW-1:0] {
    EX_ADD32T  = 6'd0,  EX_ADD32W  = 6'd1,  EX_SUB32T  = 6'd2,  EX_SUB32W  = 6'd3,
    EX_ADD64T  = 6'd4,  EX_ADD64W  = 6'd5,  EX_SUB64T  = 6'd6,  EX_SUB64W  = 6'd7,
    EX_ADDI32T = 6'd8,  EX_ADDI32W = 6'd9,  EX_ADDI64T = 6'd10, EX_ADDI64W = 6'd11,
    EX_AND     = 6'd12, EX_OR      = 6'd13, EX_XOR     = 6'd14, EX_NOR     = 6'd15,
    EX_ANDI    = 6'd16, EX_ORI     = 6'd17, EX_XORI    = 6'd18, EX_LUI     = 6'd19,
    EX_SLT     = 6'd20, EX_SLTU    = 6'd21, EX_SLTI    = 6'd22, EX_SLTIU   = 6'd23,
    EX_SHL32   = 6'd24, EX_SHR32   = 6'd25, EX_SRA32   = 6'd26,
    EX_SHL32V  = 6'd27, EX_SHR32V  = 6'd28, EX_SRA32V  = 6'd29,
    EX_SHL64   = 6'd30, EX_SHR64   = 6'd31, EX_SRA64   = 6'd32,
    EX_SHL64P  = 6'd33, EX_SHR64P  = 6'd34, EX_SRA64P  = 6'd35,
    EX_SHL64V  = 6'd36, EX_SHR64V  = 6'd37, EX_SRA64V  = 6'd38
  } exu_op_e;

  typedef enum logic [1:0] {CLS_NONE, CLS_ARITH, CLS_LOGIC, CLS_SHIFT} exu_cls_e;
  typedef enum logic [1:0] {SHK_LEFT, SHK_RLOG, SHK_RARI} exu_shk_e;

  function automatic logic [XLEN-1:0] sext_half(input logic [HLEN-1:0] v);
    return {{(XLEN-HLEN){v[HLEN-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
    return {{(XLEN-IMMW){v[IMMW-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zext_imm(input logic [IMMW-1:0] v);
    return {{(XLEN-IMMW){1'b0}}, v};
  endfunction

  function automatic exu_cls_e op_class(input exu_op_e op);
    if (op <= EX_ADDI64W)     return CLS_ARITH;
    else if (op <= EX_SLTIU)  return CLS_LOGIC;
    else if (op <= EX_SRA64V) return CLS_SHIFT;
    else                      return CLS_NONE;
  endfunction

  function automatic logic op_traps(input exu_op_e op);
    return (op == EX_ADD32T) || (op == EX_SUB32T) || (op == EX_ADD64T) ||
           (op == EX_SUB64T) || (op == EX_ADDI32T) || (op == EX_ADDI64T);
  endfunction

endpackage

// File: rtl/exu_addsub.sv
module exu_addsub
  import exu_pkg::*;
(
  input  exu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] imm_sx_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_evt_o
);

  logic            hit, is_sub, is_wide, is_trap, use_imm;
  logic [XLEN-1:0] rhs, rhs_wide;
  logic [HLEN:0]   lhs_n, rhs_n, sum_n;
  logic [XLEN-1:0] sum_w;
  logic            ovf_n, ovf_w;

  always_comb begin
    hit = 1'b1; is_sub = 1'b0; is_wide = 1'b0; is_trap = 1'b0; use_imm = 1'b0;
    unique case (op_i)
      EX_ADD32T:  is_trap = 1'b1;
      EX_ADD32W:  ;
      EX_SUB32T:  begin is_sub = 1'b1; is_trap = 1'b1; end
      EX_SUB32W:  is_sub = 1'b1;
      EX_ADD64T:  begin is_wide = 1'b1; is_trap = 1'b1; end
      EX_ADD64W:  is_wide = 1'b1;
      EX_SUB64T:  begin is_wide = 1'b1; is_sub = 1'b1; is_trap = 1'b1; end
      EX_SUB64W:  begin is_wide = 1'b1; is_sub = 1'b1; end
      EX_ADDI32T: begin use_imm = 1'b1; is_trap = 1'b1; end
      EX_ADDI32W: use_imm = 1'b1;
      EX_ADDI64T: begin use_imm = 1'b1; is_wide = 1'b1; is_trap = 1'b1; end
      EX_ADDI64W: begin use_imm = 1'b1; is_wide = 1'b1; end
      default:    hit = 1'b0;
    endcase
  end

  assign rhs = use_imm ? imm_sx_i : b_i;

  // Word path: 33-bit signed sum, overflow when the two top bits disagree.
  assign lhs_n = {a_i[HLEN-1], a_i[HLEN-1:0]};
  always_comb begin
    rhs_n = {rhs[HLEN-1], rhs[HLEN-1:0]};
    if (is_sub) rhs_n = ~rhs_n + (HLEN+1)'(1);
  end
  assign sum_n = lhs_n + rhs_n;
  assign ovf_n = sum_n[HLEN] ^ sum_n[HLEN-1];

  // Doubleword path: inverted operand plus carry-in, same-sign overflow rule.
  assign rhs_wide = is_sub ? ~rhs : rhs;
  assign sum_w    = a_i + rhs_wide + XLEN'(is_sub);
  assign ovf_w    = (a_i[XLEN-1] == rhs_wide[XLEN-1]) && (sum_w[XLEN-1] != a_i[XLEN-1]);

  assign sum_o     = !hit ? '0 : (is_wide ? sum_w : sext_half(sum_n[HLEN-1:0]));
  assign ovf_evt_o = hit && is_trap && (is_wide ? ovf_w : ovf_n);

  always_comb begin
    if (ovf_evt_o && is_wide && !is_sub && !use_imm) begin
      p_wide_ovf_sign_r4: assert (sum_o[XLEN-1] != b_i[XLEN-1] && a_i[XLEN-1] == b_i[XLEN-1])
        else $error("doubleword overflow without a sign flip");
    end
  end

endmodule

// File: rtl/exu_shift_core.sv
module exu_shift_core
  import exu_pkg::*;
#(
  parameter int W  = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [AW-1:0] amt_i,
  input  exu_shk_e      kind_i,
  output logic [W-1:0]  res_o
);

  always_comb begin
    unique case (kind_i)
      SHK_LEFT: res_o = val_i << amt_i;
      SHK_RLOG: res_o = val_i >> amt_i;
      SHK_RARI: res_o = $signed(val_i) >>> amt_i;
      default:  res_o = '0;
    endcase
  end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
  import exu_pkg::*;
(
  input  exu_op_e         op_i,
  input  logic [XLEN-1:0] val_i,
  input  logic [SHW-1:0]  reg_amt_i,
  input  logic [REGW-1:0] shamt_i,
  output logic [XLEN-1:0] res_o
);

  logic           hit, is_wide;
  exu_shk_e       kind;
  logic [SHW-1:0] amt;
  logic [XLEN-1:0] core_res [2];

  always_comb begin
    hit = 1'b1; is_wide = 1'b0; kind = SHK_LEFT; amt = {1'b0, shamt_i};
    unique case (op_i)
      EX_SHL32:  kind = SHK_LEFT;
      EX_SHR32:  kind = SHK_RLOG;
      EX_SRA32:  kind = SHK_RARI;
      EX_SHL32V: begin kind = SHK_LEFT; amt = {1'b0, reg_amt_i[REGW-1:0]}; end
      EX_SHR32V: begin kind = SHK_RLOG; amt = {1'b0, reg_amt_i[REGW-1:0]}; end
      EX_SRA32V: begin kind = SHK_RARI; amt = {1'b0, reg_amt_i[REGW-1:0]}; end
      EX_SHL64:  begin kind = SHK_LEFT; is_wide = 1'b1; end
      EX_SHR64:  begin kind = SHK_RLOG; is_wide = 1'b1; end
      EX_SRA64:  begin kind = SHK_RARI; is_wide = 1'b1; end
      EX_SHL64P: begin kind = SHK_LEFT; is_wide = 1'b1; amt = {1'b1, shamt_i}; end
      EX_SHR64P: begin kind = SHK_RLOG; is_wide = 1'b1; amt = {1'b1, shamt_i}; end
      EX_SRA64P: begin kind = SHK_RARI; is_wide = 1'b1; amt = {1'b1, shamt_i}; end
      EX_SHL64V: begin kind = SHK_LEFT; is_wide = 1'b1; amt = reg_amt_i; end
      EX_SHR64V: begin kind = SHK_RLOG; is_wide = 1'b1; amt = reg_amt_i; end
      EX_SRA64V: begin kind = SHK_RARI; is_wide = 1'b1; amt = reg_amt_i; end
      default:   hit = 1'b0;
    endcase
  end

  // One core per operating width; the narrow one re-extends its sign.
  for (genvar g = 0; g < 2; g++) begin : g_core
    localparam int CW = (g == 0) ? HLEN : XLEN;
    localparam int CA = $clog2(CW);
    logic [CW-1:0] r;
    exu_shift_core #(.W(CW)) u_core (
      .val_i  (val_i[CW-1:0]),
      .amt_i  (amt[CA-1:0]),
      .kind_i (kind),
      .res_o  (r)
    );
    if (g == 0) begin : g_narrow
      assign core_res[g] = sext_half(r);
    end else begin : g_wide
      assign core_res[g] = r;
    end
  end

  assign res_o = !hit ? '0 : core_res[is_wide ? 1 : 0];

  always_comb begin
    if (hit && kind == SHK_RLOG && !is_wide && amt != '0) begin
      p_shr32_clears_top_r10: assert (res_o[XLEN-1:HLEN-1] == '0)
        else $error("word logical right shift left upper bits set");
    end
    if (hit && kind == SHK_RLOG && is_wide && amt != '0) begin
      p_shr64_msb_clear_r11: assert (!res_o[XLEN-1])
        else $error("doubleword logical right shift kept the msb");
    end
  end

endmodule

// File: rtl/exu_logic.sv
module exu_logic
  import exu_pkg::*;
(
  input  exu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [XLEN-1:0] res_o
);

  logic [XLEN-1:0] imm_z, imm_s, upper;
  logic            lt_s_reg, lt_u_reg, lt_s_imm, lt_u_imm;

  assign imm_z = zext_imm(imm_i);
  assign imm_s = sext_imm(imm_i);
  assign upper = sext_half({imm_i, {(HLEN-IMMW){1'b0}}});

  assign lt_s_reg = $signed(a_i) < $signed(b_i);
  assign lt_u_reg = a_i < b_i;
  assign lt_s_imm = $signed(a_i) < $signed(imm_s);
  assign lt_u_imm = a_i < imm_s;

  always_comb begin
    unique case (op_i)
      EX_AND:   res_o = a_i & b_i;
      EX_OR:    res_o = a_i | b_i;
      EX_XOR:   res_o = a_i ^ b_i;
      EX_NOR:   res_o = ~(a_i | b_i);
      EX_ANDI:  res_o = a_i & imm_z;
      EX_ORI:   res_o = a_i | imm_z;
      EX_XORI:  res_o = a_i ^ imm_z;
      EX_LUI:   res_o = upper;
      EX_SLT:   res_o = XLEN'(lt_s_reg);
      EX_SLTU:  res_o = XLEN'(lt_u_reg);
      EX_SLTI:  res_o = XLEN'(lt_s_imm);
      EX_SLTIU: res_o = XLEN'(lt_u_imm);
      default:  res_o = '0;
    endcase
  end

  always_comb begin
    if ((op_i == EX_SLT || op_i == EX_SLTU) && a_i == b_i) begin
      p_equal_not_less_r8: assert (res_o == '0)
        else $error("equal operands compared as less");
    end
  end

endmodule

// File: rtl/exu_int_alu.sv
module exu_int_alu
  import exu_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [REGW-1:0] shamt_i,
  input  logic [REGW-1:0] dest_i,
  output logic [XLEN-1:0] result_o,
  output logic            wr_en_o,
  output logic            ovf_o,
  output logic [EXCW-1:0] exc_code_o
);

  exu_op_e         op;
  exu_cls_e        cls;
  logic [XLEN-1:0] arith_res, logic_res, shift_res;
  logic            ovf_evt;

  assign op  = exu_op_e'(op_i);
  assign cls = op_class(op);

  exu_addsub u_addsub (
    .op_i      (op),
    .a_i       (src_a_i),
    .b_i       (src_b_i),
    .imm_sx_i  (sext_imm(imm_i)),
    .sum_o     (arith_res),
    .ovf_evt_o (ovf_evt)
  );

  exu_logic u_logic (
    .op_i  (op),
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .imm_i (imm_i),
    .res_o (logic_res)
  );

  exu_shifter u_shifter (
    .op_i      (op),
    .val_i     (src_b_i),
    .reg_amt_i (src_a_i[SHW-1:0]),
    .shamt_i   (shamt_i),
    .res_o     (shift_res)
  );

  always_comb begin
    unique case (cls)
      CLS_ARITH: result_o = arith_res;
      CLS_LOGIC: result_o = logic_res;
      CLS_SHIFT: result_o = shift_res;
      default:   result_o = '0;
    endcase
  end

  assign ovf_o      = ovf_evt;
  assign wr_en_o    = (cls != CLS_NONE) && (dest_i != '0) && !ovf_evt;
  assign exc_code_o = ovf_evt ? EXC_OVF : '0;

  always_comb begin
    if (dest_i == '0) begin
      p_no_zero_write_r5: assert (!wr_en_o) else $error("write to register zero");
    end
    if (ovf_o) begin
      p_ovf_blocks_write_r6: assert (!wr_en_o) else $error("write despite overflow");
      p_ovf_only_trapping_r3: assert (op_traps(op)) else $error("overflow on non-trapping op");
    end
    if (cls == CLS_NONE) begin
      p_unused_op_quiet_r1: assert (result_o == '0 && !ovf_o && !wr_en_o)
        else $error("unused opcode produced activity");
    end
  end

endmodule

// File: tb/exu_int_alu_tb.sv
module exu_int_alu_tb_top;

  logic        clk = 1'b0;
  logic [5:0]  op;
  logic [63:0] a, b;
  logic [15:0] imm;
  logic [4:0]  sh, dst;
  logic [63:0] res;
  logic        we, ov;
  logic [5:0]  exc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  exu_int_alu dut_i (
    .op_i(op), .src_a_i(a), .src_b_i(b), .imm_i(imm), .shamt_i(sh), .dest_i(dst),
    .result_o(res), .wr_en_o(we), .ovf_o(ov), .exc_code_o(exc)
  );

  localparam logic [63:0] VALS [14] = '{
    64'h0, 64'h1, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_7fff_ffff,
    64'h0000_0000_8000_0000, 64'h0000_0000_ffff_ffff, 64'h0000_0001_0000_0000,
    64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000, 64'h0123_4567_89ab_cdef,
    64'hfedc_ba98_7654_3210, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_003f,
    64'hffff_ffff_8000_0000
  };
  localparam logic [15:0] IMMS [6] = '{16'h0, 16'h1, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
  localparam logic [4:0]  SHS  [8] = '{5'd0, 5'd1, 5'd31, 5'd4, 5'd16, 5'd8, 5'd30, 5'd2};

  // Independent reference built from the requirement text.
  task automatic model(input logic [5:0] o, input logic [63:0] x, input logic [63:0] y,
                       input logic [15:0] im, input logic [4:0] s,
                       output logic [63:0] r, output logic f, output logic valid,
                       output string tag);
    logic [63:0] sxi, zxi, rhs;
    longint lx, ly, t;
    logic signed [64:0] w;
    logic [31:0] lo, tmp;
    int n;
    bit trap;
    sxi = {{48{im[15]}}, im};
    zxi = {48'h0, im};
    r = '0; f = 1'b0; valid = 1'b1; tag = "R1";
    trap = (o == 0) || (o == 2) || (o == 4) || (o == 6) || (o == 8) || (o == 10);
    if (o <= 3 || o == 8 || o == 9) begin
      tag = trap ? "R3" : "R2";
      lx = longint'($signed(x[31:0]));
      ly = (o >= 8) ? longint'($signed(sxi[31:0])) : longint'($signed(y[31:0]));
      t  = (o == 2 || o == 3) ? lx - ly : lx + ly;
      r  = {{32{t[31]}}, t[31:0]};
      f  = trap && (t > 64'sd2147483647 || t < -64'sd2147483648);
    end else if (o <= 11) begin
      tag = "R4";
      rhs = (o >= 10) ? sxi : y;
      if (o == 6 || o == 7) w = $signed({x[63], x}) - $signed({rhs[63], rhs});
      else                  w = $signed({x[63], x}) + $signed({rhs[63], rhs});
      r = w[63:0];
      f = trap && (w[64] != w[63]);
    end else if (o <= 18 || o == 19) begin
      tag = (o == 19) ? "R9" : "R7";
      case (o)
        12: r = x & y;
        13: r = x | y;
        14: r = x ^ y;
        15: r = ~(x | y);
        16: r = x & zxi;
        17: r = x | zxi;
        18: r = x ^ zxi;
        default: r = {{32{im[15]}}, im, 16'h0};
      endcase
    end else if (o <= 23) begin
      tag = "R8";
      case (o)
        20: r = {63'h0, $signed(x) < $signed(y)};
        21: r = {63'h0, x < y};
        22: r = {63'h0, $signed(x) < $signed(sxi)};
        default: r = {63'h0, x < sxi};
      endcase
    end else if (o <= 29) begin
      tag = "R10";
      n  = (o < 27) ? int'(s) : int'(x[4:0]);
      lo = y[31:0];
      case ((o - 24) % 3)
        0: tmp = lo << n;
        1: tmp = lo >> n;
        default: tmp = $signed(lo) >>> n;
      endcase
      r = {{32{tmp[31]}}, tmp};
    end else if (o <= 38) begin
      tag = "R11";
      n = (o < 33) ? int'(s) : (o < 36) ? int'(s) + 32 : int'(x[5:0]);
      case ((o - 30) % 3)
        0: r = y << n;
        1: r = y >> n;
        default: r = $signed(y) >>> n;
      endcase
    end else begin
      valid = 1'b0;
    end
  endtask

  task automatic apply(input logic [5:0] o, input logic [63:0] x, input logic [63:0] y,
                       input logic [15:0] im, input logic [4:0] s, input logic [4:0] d);
    @(posedge clk);
    #1;
    op = o; a = x; b = y; imm = im; sh = s; dst = d;
    @(negedge clk);
  endtask

  task automatic compare(input string tag, input logic [63:0] er, input logic ew,
                         input logic eo);
    logic [5:0] ee;
    ee = eo ? 6'h30 : 6'h0;
    n_checks++;
    if (res !== er || we !== ew || ov !== eo || exc !== ee) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d d=%0d | act res=%h we=%b ov=%b exc=%h | exp res=%h we=%b ov=%b exc=%h",
               tag, op, a, b, imm, sh, dst, res, we, ov, exc, er, ew, eo, ee);
    end
  endtask

  task automatic run_model(input logic [5:0] o, input logic [63:0] x, input logic [63:0] y,
                           input logic [15:0] im, input logic [4:0] s, input logic [4:0] d);
    logic [63:0] er;
    logic eo, ok;
    string tag;
    apply(o, x, y, im, s, d);
    model(o, x, y, im, s, er, eo, ok, tag);
    compare(tag, er, ok && d != 0 && !eo, eo);
  endtask

  initial begin
    op = '0; a = '0; b = '0; imm = '0; sh = '0; dst = '0;
    @(negedge clk);
    // R1: idle inputs are an ADD32T of zeros to register zero: nothing written.
    compare("R1", 64'h0, 1'b0, 1'b0);

    // Directed corners with literal expectations.
    apply(6'd0, 64'h7fff_ffff, 64'h1, 16'h0, 5'd0, 5'd0);                 // R5 overflow at dest 0
    compare("R5", 64'hffff_ffff_8000_0000, 1'b0, 1'b1);
    apply(6'd0, 64'h7fff_ffff, 64'h1, 16'h0, 5'd0, 5'd7);                 // R6 overflow blocks write
    compare("R6", 64'hffff_ffff_8000_0000, 1'b0, 1'b1);
    apply(6'd1, 64'h7fff_ffff, 64'h1, 16'h0, 5'd0, 5'd7);                 // R2 wraps silently
    compare("R2", 64'hffff_ffff_8000_0000, 1'b1, 1'b0);
    apply(6'd6, 64'h0, 64'h8000_0000_0000_0000, 16'h0, 5'd0, 5'd3);       // R4 0 - min overflows
    compare("R4", 64'h8000_0000_0000_0000, 1'b0, 1'b1);
    apply(6'd25, 64'h0, 64'h0000_0000_8000_0000, 16'h0, 5'd0, 5'd2);      // R10 shr by 0 sign-extends
    compare("R10", 64'hffff_ffff_8000_0000, 1'b1, 1'b0);
    apply(6'd35, 64'h0, 64'h8000_0000_0000_0000, 16'h0, 5'd31, 5'd2);     // R11 sra by 63
    compare("R11", 64'hffff_ffff_ffff_ffff, 1'b1, 1'b0);
    apply(6'd19, 64'h0, 64'h0, 16'h8001, 5'd0, 5'd1);                     // R9
    compare("R9", 64'hffff_ffff_8001_0000, 1'b1, 1'b0);
    apply(6'd16, 64'hffff_ffff_ffff_ffff, 64'h0, 16'h8001, 5'd0, 5'd1);   // R7 zero-extended imm
    compare("R7", 64'h0000_0000_0000_8001, 1'b1, 1'b0);
    apply(6'd23, 64'h5, 64'h0, 16'hffff, 5'd0, 5'd1);                     // R8 unsigned vs all ones
    compare("R8", 64'h1, 1'b1, 1'b0);
    apply(6'd40, 64'h5, 64'h7, 16'h1, 5'd1, 5'd1);                        // R1 unused code
    compare("R1", 64'h0, 1'b0, 1'b0);

    // Sweep every code over operand corners, rotating imm, shamt and dest.
    for (int o = 0; o < 64; o++) begin
      for (int i = 0; i < 14; i++) begin
        for (int j = 0; j < 14; j++) begin
          run_model(6'(o), VALS[i], VALS[j], IMMS[(i + j) % 6], SHS[(i * 3 + j) % 8],
                    5'((i + j + o) % 4));
        end
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule